// File: doc/BRIEF.md
# Nine-Bit Asynchronous Serial Port with Stop-Bit Checking

This block is a full-duplex asynchronous serial port that sends and receives 11-bit frames. Every frame has a low start bit, eight data bits with the least significant bit first, a programmable ninth bit and a high stop bit. Software reaches the port through a small register bus with two addresses: a control/status word and a data buffer. A write to the data buffer sends a byte, with the ninth bit taken from the control word. A received byte can be read back from the same address. Its ninth bit appears in the control word.

Bit timing comes from an external strobe, `baud_tick`, which runs at 16 times the bit rate. The receiver syncs the line and waits for a falling edge. It then takes a 2-of-3 majority vote at oversamples 7, 8 and 9 of each bit. A start bit that votes high is dropped as a glitch. The stop-bit check is enabled by the `frame_chk_en` input, which does two things when set. It reuses control bit 7, which otherwise holds the mode bit, as a sticky framing-error flag. It also delays the receive-done flag from the ninth bit to the stop bit.

The two serial modes, control bits 7:6 = 10 and 11, carry the same frame on the same tick. Modes 00 and 01 are unselected. In those modes the transmitter idles high and neither side shifts.

Top module: `uart9_port`

## Requirements
- R1: `txd` idles high. A frame drives a low start bit, then data bits 0 to 7, then the ninth bit from control bit 3, then a high stop bit. Each bit lasts 16 `baud_tick` strobes.
- R2: A write to address 1 starts a frame on the next clock edge, but only when control bit 7 (the mode bit) is 1 and no frame is in progress. A write while a frame is in progress, or while the mode bit is 0, sends nothing.
- R3: The transmit-done flag, control bit 1, rises when the stop bit begins. It stays set until software writes 0 to it.
- R4: A receive starts only when control bit 4 (receive enable) is 1, the mode bit is 1, and the line falls from high to low. The received byte is read at address 1 and the ninth bit at control bit 2.
- R5: Each received bit is the majority of three samples taken at oversamples 7, 8 and 9. A start bit that votes high is dropped, no frame is delivered, and the receiver waits for the next falling edge.
- R6: The receive-done flag, control bit 0, rises at the ninth-bit vote when `frame_chk_en` is 0 and at the stop-bit vote when it is 1. It stays set until software writes 0 to it.
- R7: With `frame_chk_en` at 1, a stop bit that votes low sets the framing-error flag. The flag is cleared only by reset or by a control write of 0 to bit 7 while `frame_chk_en` is 1. Writing 1 to it, or receiving later good frames, leaves it set.
- R8: Control bit 7 reads and writes the mode bit when `frame_chk_en` is 0, and the framing-error flag when it is 1. In the second case a control write leaves the mode bit unchanged.
- R9: A frame that completes while the receive-done flag is still set is discarded. The receive buffer and the ninth-bit copy keep their old values.
- R10: If the receiver completes a frame in the same cycle as a control write that clears the receive-done flag, the flag is set and the frame is stored.
- R11: After reset, the control word reads 0, `rd_data` is 0 and `txd` is high.
- R12: `rd_data` shows the register selected by `bus_addr` (0 for control, 1 for the receive buffer) one clock after the address is presented. Control bit 5 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | One-cycle strobe at 16x the bit rate |
| frame_chk_en | input | 1 | Enables the stop-bit check and remaps control bit 7 |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 1 | 0 selects control/status, 1 selects the data buffer |
| bus_wdata | input | DATA_W | Write data |
| rd_data | output | DATA_W | Registered read data |
| rxd | input | 1 | Serial receive line, asynchronous |
| txd | output | 1 | Serial transmit line |

## Verification
A frame can complete in the receiver in the same clock as a software control write that clears the receive-done flag. The hardware set and the software clear then meet on the same register. The bench holds the write strobe high with a clearing value on every cycle of a whole incoming frame. It then counts how many cycles the readback shows the flag set. The hardware set must win, so the flag is seen for exactly one cycle and the byte lands in the buffer. A design that lets software win never shows the flag at all. Separately, the early-versus-late timing of the done flag is judged a quarter bit into the stop bit, once with the check enabled and once with it disabled.

// File: rtl/uart9_pkg.sv
package uart9_pkg;
  // Control/status word bit positions
  localparam int CTL_MODE_HI = 7;  // mode bit, or framing-error flag when checking
  localparam int CTL_MODE_LO = 6;
  localparam int CTL_REN     = 4;
  localparam int CTL_TB8     = 3;
  localparam int CTL_RB8     = 2;
  localparam int CTL_TI      = 1;
  localparam int CTL_RI      = 0;

  // Register addresses
  localparam logic ADDR_CTL = 1'b0;
  localparam logic ADDR_DAT = 1'b1;

  // 2-of-3 majority vote
  function automatic logic vote3(input logic [2:0] s);
    return (s[0] & s[1]) | (s[0] & s[2]) | (s[1] & s[2]);
  endfunction
endpackage

// File: rtl/uart9_tx.sv
module uart9_tx #(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              enable,
  input  logic              start,
  input  logic [DATA_W-1:0] data,
  input  logic              bit9,
  output logic              txd,
  output logic              stop_begin
);
  localparam int FRAME = DATA_W + 3;
  localparam int CW    = $clog2(OVS);
  localparam int IW    = $clog2(FRAME + 1);

  logic [FRAME-1:0] sh;
  logic [CW-1:0]    cnt;
  logic [IW-1:0]    idx;
  logic             busy;

  always_ff @(posedge clk) begin
    stop_begin <= 1'b0;
    if (rst) begin
      sh   <= '0;
      cnt  <= '0;
      idx  <= '0;
      busy <= 1'b0;
      txd  <= 1'b1;
    end else if (!enable) begin
      busy <= 1'b0;
      txd  <= 1'b1;
      cnt  <= '0;
      idx  <= '0;
    end else if (start && !busy) begin
      sh   <= {1'b1, bit9, data, 1'b0};
      busy <= 1'b1;
      txd  <= 1'b0;
      cnt  <= '0;
      idx  <= '0;
    end else if (busy && tick) begin
      if (cnt == CW'(OVS - 1)) begin
        cnt <= '0;
        if (idx == IW'(FRAME - 1)) begin
          busy <= 1'b0;
          txd  <= 1'b1;
        end else begin
          idx <= idx + IW'(1);
          sh  <= {1'b1, sh[FRAME-1:1]};
          txd <= sh[1];
          if (idx == IW'(FRAME - 2)) stop_begin <= 1'b1;
        end
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end

  AST_TX_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
    !busy |-> txd);  // R1
  AST_TX_START_LOW: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && enable) |=> (busy && !txd));  // R2
  AST_TX_STOP_HIGH: assert property (@(posedge clk) disable iff (rst)
    stop_begin |-> (txd && busy));  // R3
endmodule

// File: rtl/uart9_rx.sv
module uart9_rx
  import uart9_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              enable,
  input  logic              ren,
  input  logic              chk_stop,
  input  logic              rxd,
  output logic              done,
  output logic              stop_bad,
  output logic [DATA_W-1:0] dout,
  output logic              bit9_out
);
  localparam int FRAME = DATA_W + 3;
  localparam int CW    = $clog2(OVS);
  localparam int IW    = $clog2(FRAME + 1);
  localparam int MID   = OVS / 2;

  logic [SYNC_STAGES-1:0] sync;
  logic                   line, line_q;
  logic [CW-1:0]          cnt;
  logic [IW-1:0]          idx;
  logic [1:0]             smp;
  logic [DATA_W:0]        sh;
  logic                   busy;
  logic                   bitval;

  assign line     = sync[SYNC_STAGES-1];
  assign bitval   = vote3({smp, line});
  assign dout     = sh[DATA_W-1:0];
  assign bit9_out = sh[DATA_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      sync   <= '1;
      line_q <= 1'b1;
    end else begin
      sync   <= {sync[SYNC_STAGES-2:0], rxd};
      line_q <= line;
    end
  end

  always_ff @(posedge clk) begin
    done     <= 1'b0;
    stop_bad <= 1'b0;
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
      idx  <= '0;
      smp  <= '0;
      sh   <= '0;
    end else if (!enable) begin
      busy <= 1'b0;
    end else if (!busy) begin
      if (ren && line_q && !line) begin
        busy <= 1'b1;
        cnt  <= '0;
        idx  <= '0;
      end
    end else if (tick) begin
      cnt <= (cnt == CW'(OVS - 1)) ? '0 : cnt + CW'(1);
      if (cnt == CW'(MID - 1) || cnt == CW'(MID)) smp <= {smp[0], line};
      if (cnt == CW'(MID + 1)) begin
        idx <= idx + IW'(1);
        if (idx == IW'(0)) begin
          if (bitval) busy <= 1'b0;  // glitch, not a start bit
        end else if (idx <= IW'(DATA_W + 1)) begin
          sh <= {bitval, sh[DATA_W:1]};
        end
        if (idx == IW'(DATA_W + 1) && !chk_stop) done <= 1'b1;
        if (idx == IW'(FRAME - 1)) begin
          busy <= 1'b0;
          if (chk_stop) begin
            done     <= 1'b1;
            stop_bad <= !bitval;
          end
        end
      end
    end
  end

  AST_RX_START_NEEDS_REN: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(ren));  // R4
  AST_RX_BAD_STOP_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    stop_bad |-> (done && chk_stop));  // R7
endmodule

// File: rtl/uart9_regs.sv
module uart9_regs
  import uart9_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fe_sel,
  input  logic              we,
  input  logic              addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              mode_sel,
  output logic              ren,
  output logic              tb8,
  output logic              tx_start,
  output logic [DATA_W-1:0] tx_data,
  input  logic              ti_set,
  input  logic              rx_done,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_bit9,
  input  logic              rx_stop_bad
);
  logic              sm0, sm1, rb8, ti, ri, fe;
  logic [DATA_W-1:0] rbuf;
  logic [DATA_W-1:0] ctl_word;
  logic              ctl_we, rx_accept;

  assign ctl_we    = we && (addr == ADDR_CTL);
  assign tx_start  = we && (addr == ADDR_DAT);
  assign tx_data   = wdata;
  assign mode_sel  = sm0;
  assign rx_accept = rx_done && !ri;

  always_comb begin
    ctl_word              = '0;
    ctl_word[CTL_MODE_HI] = fe_sel ? fe : sm0;
    ctl_word[CTL_MODE_LO] = sm1;
    ctl_word[CTL_REN]     = ren;
    ctl_word[CTL_TB8]     = tb8;
    ctl_word[CTL_RB8]     = rb8;
    ctl_word[CTL_TI]      = ti;
    ctl_word[CTL_RI]      = ri;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sm0     <= 1'b0;
      sm1     <= 1'b0;
      ren     <= 1'b0;
      tb8     <= 1'b0;
      rb8     <= 1'b0;
      ti      <= 1'b0;
      ri      <= 1'b0;
      fe      <= 1'b0;
      rbuf    <= '0;
      rd_data <= '0;
    end else begin
      if (ctl_we) begin
        if (!fe_sel) sm0 <= wdata[CTL_MODE_HI];
        sm1 <= wdata[CTL_MODE_LO];
        ren <= wdata[CTL_REN];
        tb8 <= wdata[CTL_TB8];
      end
      // hardware set takes priority over a software write
      ti <= ti_set    | (ctl_we ? wdata[CTL_TI] : ti);
      ri <= rx_accept | (ctl_we ? wdata[CTL_RI] : ri);
      fe <= rx_stop_bad | (fe & ~(ctl_we & fe_sel & ~wdata[CTL_MODE_HI]));
      if (rx_accept) begin
        rbuf <= rx_data;
        rb8  <= rx_bit9;
      end
      rd_data <= (addr == ADDR_DAT) ? rbuf : ctl_word;
    end
  end

  AST_FE_STICKY: assert property (@(posedge clk) disable iff (rst)
    (fe && !(ctl_we && fe_sel && !wdata[CTL_MODE_HI])) |=> fe);  // R7
  AST_RI_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    (rx_done && !ri) |=> ri);  // R10
  AST_RBUF_HELD: assert property (@(posedge clk) disable iff (rst)
    (ri && !(ctl_we && !wdata[CTL_RI])) |=> ($stable(rbuf) && $stable(rb8)));  // R9
  AST_SM0_KEPT: assert property (@(posedge clk) disable iff (rst)
    (ctl_we && fe_sel) |=> $stable(sm0));  // R8
endmodule

// File: rtl/uart9_port.sv
module uart9_port #(
  parameter int DATA_W      = 8,
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              baud_tick,
  input  logic              frame_chk_en,
  input  logic              bus_we,
  input  logic              bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] rd_data,
  input  logic              rxd,
  output logic              txd
);
  logic              mode_sel, ren, tb8, tx_start, ti_set;
  logic [DATA_W-1:0] tx_data, rx_data;
  logic              rx_done, rx_bit9, rx_stop_bad;

  uart9_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .fe_sel(frame_chk_en),
    .we(bus_we), .addr(bus_addr), .wdata(bus_wdata), .rd_data(rd_data),
    .mode_sel(mode_sel), .ren(ren), .tb8(tb8),
    .tx_start(tx_start), .tx_data(tx_data), .ti_set(ti_set),
    .rx_done(rx_done), .rx_data(rx_data), .rx_bit9(rx_bit9),
    .rx_stop_bad(rx_stop_bad)
  );

  uart9_tx #(.DATA_W(DATA_W), .OVS(OVS)) u_tx (
    .clk(clk), .rst(rst), .tick(baud_tick), .enable(mode_sel),
    .start(tx_start), .data(tx_data), .bit9(tb8),
    .txd(txd), .stop_begin(ti_set)
  );

  uart9_rx #(.DATA_W(DATA_W), .OVS(OVS), .SYNC_STAGES(SYNC_STAGES)) u_rx (
    .clk(clk), .rst(rst), .tick(baud_tick), .enable(mode_sel), .ren(ren),
    .chk_stop(frame_chk_en), .rxd(rxd),
    .done(rx_done), .stop_bad(rx_stop_bad), .dout(rx_data), .bit9_out(rx_bit9)
  );
endmodule

// File: tb/uart9_port_tb.sv
module uart9_port_tb;
  localparam int TICK_DIV = 4;
  localparam int BIT_CLK  = 64;

  logic       clk = 1'b0, rst = 1'b1, baud_tick = 1'b0, fe_sel = 1'b0;
  logic       bus_we = 1'b0, bus_addr = 1'b0, rxd = 1'b1;
  logic [7:0] bus_wdata = 8'h00;
  wire  [7:0] rd_data;
  wire        txd;
  int         checks = 0, errors = 0, tdiv = 0;
  logic       finished = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  always @(posedge clk) begin
    tdiv      <= (tdiv == TICK_DIV - 1) ? 0 : tdiv + 1;
    baud_tick <= (tdiv == TICK_DIV - 1);
  end

  uart9_port u_dut (
    .clk(clk), .rst(rst), .baud_tick(baud_tick), .frame_chk_en(fe_sel),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rd_data(rd_data), .rxd(rxd), .txd(txd)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clocks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic a, input logic [7:0] v);
    @(negedge clk);
    bus_addr = a; bus_wdata = v; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; bus_addr = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] v);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    v = rd_data;
    bus_addr = 1'b0;
  endtask

  function automatic logic frame_bit(input logic [7:0] d, input logic b9, input int k);
    if (k == 0) return 1'b0;
    if (k <= 8) return d[k-1];
    if (k == 9) return b9;
    return 1'b1;
  endfunction

  function automatic logic [7:0] ctl_val(input logic tb8, input logic ren);
    return {1'b1, 1'b1, 1'b0, ren, tb8, 3'b000};
  endfunction

  // Drive one frame; early_ri is the done flag a quarter bit into the stop bit
  task automatic send_frame(input logic [7:0] d, input logic b9, input logic stop,
                            output logic early_ri);
    for (int k = 0; k < 10; k++) begin
      rxd = frame_bit(d, b9, k);
      clocks(BIT_CLK);
    end
    rxd = stop;
    clocks(16);
    early_ri = rd_data[0];
    clocks(BIT_CLK - 16);
    rxd = 1'b1;
  endtask

  // Called right after the data write; checks every bit and the TI timing
  task automatic tx_watch(input logic [7:0] d, input logic b9, input logic inject);
    chk("R1 start edge", txd, 1'b0);
    clocks(32);
    chk("R1 start bit", txd, 1'b0);
    for (int k = 1; k <= 10; k++) begin
      if (inject && k == 4) begin
        wr(1'b1, 8'hFF);  // ignored: frame in progress (R2)
        clocks(BIT_CLK - 2);
      end else begin
        clocks(BIT_CLK);
      end
      chk($sformatf("R1 bit %0d", k), txd, frame_bit(d, b9, k));
      if (k == 9)  chk("R3 TI low before stop", rd_data[1], 1'b0);
      if (k == 10) chk("R3 TI high at stop", rd_data[1], 1'b1);
    end
    clocks(40);
  endtask

  task automatic count_low(input int n, output int lows);
    lows = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (!txd) lows++;
    end
  endtask

  initial begin
    logic [7:0] v, d, last;
    logic       b9, e, fe;
    int         lows, ones;
    void'($urandom(32'h00C0FFEE));

    clocks(5);
    chk("R11 rd_data in reset", rd_data, 8'h00);
    chk("R11 txd in reset", txd, 1'b1);
    rst = 1'b0;
    clocks(2);
    chk("R11 control after reset", rd_data, 8'h00);

    // Unselected mode: data write sends nothing
    wr(1'b1, 8'hA5);
    count_low(800, lows);
    chk("R2 no frame while unselected", lows, 0);

    wr(1'b0, 8'hD8);
    rd(1'b0, v);
    chk("R8 bit7 shows mode bit, R12 control readback", v, 8'hD8);

    // Directed transmit with a write injected mid-frame
    wr(1'b1, 8'h3C);
    tx_watch(8'h3C, 1'b1, 1'b1);
    count_low(200, lows);
    chk("R2 busy write ignored", lows, 0);
    rd(1'b0, v);
    chk("R3 TI stays set", v[1], 1'b1);
    wr(1'b0, ctl_val(1'b0, 1'b1));
    rd(1'b0, v);
    chk("R3 TI cleared by software", v[1], 1'b0);

    // Random transmits
    for (int n = 0; n < 6; n++) begin
      d  = 8'($urandom);
      b9 = 1'($urandom);
      wr(1'b0, ctl_val(b9, 1'b1));
      wr(1'b1, d);
      tx_watch(d, b9, 1'b0);
    end
    wr(1'b0, ctl_val(1'b0, 1'b1));

    // Directed receive, check disabled
    send_frame(8'h5A, 1'b0, 1'b1, e);
    chk("R6 RI early when check off", e, 1'b1);
    clocks(BIT_CLK);
    rd(1'b0, v);
    chk("R4 RI set", v[0], 1'b1);
    chk("R4 RB8", v[2], 1'b0);
    rd(1'b1, v);
    chk("R4 R12 data buffer", v, 8'h5A);

    // Frame while RI set is discarded
    send_frame(8'hC3, 1'b1, 1'b1, e);
    clocks(BIT_CLK);
    rd(1'b1, v);
    chk("R9 buffer kept", v, 8'h5A);
    rd(1'b0, v);
    chk("R9 RB8 kept", v[2], 1'b0);
    wr(1'b0, ctl_val(1'b0, 1'b1));

    // Random receives with random check enable
    last = 8'h5A;
    for (int n = 0; n < 6; n++) begin
      d      = 8'($urandom);
      b9     = 1'($urandom);
      fe_sel = 1'($urandom);
      clocks(4);
      send_frame(d, b9, 1'b1, e);
      chk("R6 RI timing", e, !fe_sel);
      clocks(BIT_CLK);
      rd(1'b0, v);
      chk("R4 RI after frame", v[0], 1'b1);
      chk("R4 RB8", v[2], b9);
      chk("R8 bit7 (FE clear or mode bit)", v[7], !fe_sel);
      rd(1'b1, v);
      chk("R4 data", v, d);
      last = d;
      wr(1'b0, ctl_val(1'b0, 1'b1));
    end
    fe_sel = 1'b0;

    // Receive disabled
    wr(1'b0, ctl_val(1'b0, 1'b0));
    send_frame(8'h81, 1'b1, 1'b1, e);
    clocks(BIT_CLK);
    rd(1'b0, v);
    chk("R4 no RI with receive disabled", v[0], 1'b0);
    rd(1'b1, v);
    chk("R4 buffer unchanged with receive disabled", v, last);
    wr(1'b0, ctl_val(1'b0, 1'b1));

    // Start glitch
    rxd = 1'b0;
    clocks(16);
    rxd = 1'b1;
    clocks(200);
    rd(1'b0, v);
    chk("R5 glitch rejected", v[0], 1'b0);
    send_frame(8'h6E, 1'b1, 1'b1, e);
    clocks(BIT_CLK);
    rd(1'b1, v);
    chk("R5 receiver back to idle", v, 8'h6E);
    wr(1'b0, ctl_val(1'b0, 1'b1));

    // Framing error
    fe_sel = 1'b1;
    send_frame(8'h11, 1'b0, 1'b0, e);
    clocks(BIT_CLK);
    rd(1'b0, v);
    chk("R7 FE set on low stop", v[7], 1'b1);
    chk("R7 frame still delivered", v[0], 1'b1);
    wr(1'b0, ctl_val(1'b0, 1'b1));  // bit7=1: no effect on FE
    send_frame(8'h22, 1'b0, 1'b1, e);
    clocks(BIT_CLK);
    rd(1'b0, v);
    fe = v[7];
    chk("R7 FE sticky over write of 1 and good frame", fe, 1'b1);
    wr(1'b0, 8'h50);  // bit7=0 clears FE, mode bit kept
    rd(1'b0, v);
    chk("R7 FE cleared by write of 0", v[7], 1'b0);
    fe_sel = 1'b0;
    rd(1'b0, v);
    chk("R8 mode bit retained", v[7], 1'b1);
    wr(1'b1, 8'h0F);
    tx_watch(8'h0F, 1'b0, 1'b0);
    wr(1'b0, ctl_val(1'b0, 1'b1));

    // Done flag set against a software clear held on every cycle
    ones = 0;
    fork
      send_frame(8'h96, 1'b1, 1'b1, e);
      begin
        bus_addr = 1'b0; bus_wdata = ctl_val(1'b0, 1'b1); bus_we = 1'b1;
        repeat (11 * BIT_CLK) begin
          @(negedge clk);
          if (rd_data[0]) ones++;
        end
        bus_we = 1'b0;
      end
    join
    chk("R10 RI seen for one cycle", ones, 1);
    rd(1'b1, v);
    chk("R10 frame stored", v, 8'h96);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(150000 * 4);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule